// File: doc/BRIEF.md
# Hopping Energy Packet Detector

This block sits behind a one-bit envelope comparator in a low-power receiver. The receiver's local oscillator steps between the three advertising channels. The comparator bit is sampled on a strobe that runs about ten times faster than the microsecond time base. The block debounces the bit, finds where each energy burst starts and ends, and measures how long the burst lasted. It tags the burst with the channel the oscillator was tuned to when the energy first appeared.

A burst is reported only if its length fits an advertising packet and the oscillator stayed on one channel for the whole burst. A burst is rejected if it is too short, too long, or cut by a channel hop. A rejected burst produces no descriptor and adds one to a saturating drop counter. A later stage uses the accepted descriptors to rebuild symbols and messages from the order of the channels and the gaps between packets.

The controller has three states:
- `S_IDLE`: wait for a debounced rise.
- `S_BURST`: a packet is open.
- `S_DRAIN`: the burst was killed by a channel hop; wait for the energy to go away.

It has five named transitions:
- `IDLE->BURST` on a rise.
- `BURST->IDLE` on a fall, which either accepts or rejects the burst by its length.
- `BURST->DRAIN` on a channel hop.
- `DRAIN->IDLE` once the debounced level is low.
- Every state stays where it is when none of these applies.

Top module: `hop_pkt_det`

## Requirements
- R1: After reset, `pkt_valid` is 0 and `drop_cnt` is 0.
- R2: A burst opens only after 3 consecutive strobed high samples. Isolated runs of 1 or 2 high samples produce no descriptor and leave `drop_cnt` unchanged.
- R3: Runs of 1 or 2 strobed low samples inside a burst do not split it. The burst is reported once, with its full length.
- R4: A descriptor is a `pkt_valid` pulse lasting exactly one clock cycle.
  - `pkt_start` is the `time_us` value at the first high sample of the burst.
  - `pkt_len` equals the `time_us` value at the first low sample of the closing run, minus `pkt_start`.
- R5: `pkt_chan` equals `lo_chan` at the first high sample of the burst. The codes are 0, 1 and 2 for advertising channels 37, 38 and 39.
- R6: Length limits for a burst:
  - A burst whose length is between 128 and 376 µs, both limits included, is reported.
  - Any shorter or longer burst is dropped, and `drop_cnt` rises by exactly 1.
- R7: If `lo_chan` differs from the burst's channel while a burst is open, the burst is dropped and `drop_cnt` rises by 1. No descriptor follows when that energy later ends.
- R8: Comparator samples taken while `samp_stb` is 0 are ignored. When the strobe runs at half rate, a burst is still timed from its first and last strobed samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| samp_stb | input | 1 | Oversample strobe; `env_bit` is taken only when this is 1 |
| env_bit | input | 1 | Comparator output |
| lo_chan | input | 2 | Channel the oscillator is tuned to (0/1/2 = 37/38/39) |
| time_us | input | TW (32) | Free-running microsecond time base |
| pkt_valid | output | 1 | One-cycle descriptor strobe |
| pkt_chan | output | 2 | Channel of the reported burst |
| pkt_start | output | TW (32) | Start timestamp in µs |
| pkt_len | output | LW (16) | Burst length in µs |
| drop_cnt | output | EW (8) | Saturating count of rejected bursts |

## Verification
Clean bursts are driven on each channel code. These show that the channel and timestamp are captured at the burst's first sample rather than later. Bursts of exactly 127, 128, 376 and 377 µs test each side of the acceptance window. Short high glitches and short low dropouts show that the 3-sample debounce works in both directions. A burst cut by a hop, a long high period with no strobe, and a half-rate strobe separate three things: a hop abort, an unsampled input, and a slower sample clock.

// File: rtl/hopd_pkg.sv
package hopd_pkg;
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_BURST = 2'd1,
        S_DRAIN = 2'd2
    } hopd_state_e;
endpackage

// File: rtl/hopd_debounce.sv
module hopd_debounce #(
    parameter int DEB = 3,
    parameter int TW  = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stb,
    input  logic          bit_i,
    input  logic [1:0]    chan_i,
    input  logic [TW-1:0] time_i,
    output logic          lvl_o,
    output logic          rise_o,
    output logic          fall_o,
    output logic [TW-1:0] mark_t_o,
    output logic [1:0]    mark_c_o
);
    localparam int CW = $clog2(DEB + 1);

    logic [CW-1:0] cnt_q;
    logic [TW-1:0] cand_t_q;
    logic [1:0]    cand_c_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_o    <= 1'b0;
            rise_o   <= 1'b0;
            fall_o   <= 1'b0;
            cnt_q    <= '0;
            cand_t_q <= '0;
            cand_c_q <= '0;
            mark_t_o <= '0;
            mark_c_o <= '0;
        end else begin
            rise_o <= 1'b0;
            fall_o <= 1'b0;
            if (stb) begin
                if (bit_i != lvl_o) begin
                    if (cnt_q == CW'(DEB - 1)) begin
                        lvl_o    <= bit_i;
                        cnt_q    <= '0;
                        rise_o   <= bit_i;
                        fall_o   <= !bit_i;
                        mark_t_o <= (cnt_q == '0) ? time_i : cand_t_q;
                        mark_c_o <= (cnt_q == '0) ? chan_i : cand_c_q;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                        if (cnt_q == '0) begin
                            cand_t_q <= time_i;
                            cand_c_q <= chan_i;
                        end
                    end
                end else begin
                    cnt_q <= '0;
                end
            end
        end
    end

    // R2
    rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |-> $past(stb && bit_i));

    // R8
    no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stb |=> !(rise_o || fall_o));
endmodule

// File: rtl/hopd_qualify.sv
module hopd_qualify #(
    parameter int TW      = 32,
    parameter int LW      = 16,
    parameter int MIN_LEN = 128,
    parameter int MAX_LEN = 376
) (
    input  logic [TW-1:0] start_t,
    input  logic [TW-1:0] end_t,
    output logic          ok_o,
    output logic [LW-1:0] len_o
);
    logic [TW-1:0] span;

    always_comb begin
        span  = end_t - start_t;
        ok_o  = (span >= TW'(MIN_LEN)) && (span <= TW'(MAX_LEN));
        len_o = span[LW-1:0];
    end
endmodule

// File: rtl/hopd_errcnt.sv
module hopd_errcnt #(
    parameter int EW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    output logic [EW-1:0] cnt_o
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_o <= '0;
        end else if (inc && (cnt_o != '1)) begin
            cnt_o <= cnt_o + 1'b1;
        end
    end

    // R6
    err_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_o == $past(cnt_o)) || (cnt_o == $past(cnt_o) + 1'b1));
endmodule

// File: rtl/hop_pkt_det.sv
module hop_pkt_det
    import hopd_pkg::*;
#(
    parameter int TW      = 32,
    parameter int LW      = 16,
    parameter int EW      = 8,
    parameter int DEB     = 3,
    parameter int MIN_LEN = 128,
    parameter int MAX_LEN = 376
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          samp_stb,
    input  logic          env_bit,
    input  logic [1:0]    lo_chan,
    input  logic [TW-1:0] time_us,
    output logic          pkt_valid,
    output logic [1:0]    pkt_chan,
    output logic [TW-1:0] pkt_start,
    output logic [LW-1:0] pkt_len,
    output logic [EW-1:0] drop_cnt
);
    hopd_state_e   state_q, state_d;
    logic          deb_lvl, deb_rise, deb_fall;
    logic [TW-1:0] mark_t;
    logic [1:0]    mark_c;
    logic [TW-1:0] start_q;
    logic [1:0]    chan_q;
    logic          len_ok;
    logic [LW-1:0] len_val;
    logic          hop, drop;

    hopd_debounce #(.DEB(DEB), .TW(TW)) u_deb (
        .clk(clk), .rst_n(rst_n), .stb(samp_stb), .bit_i(env_bit),
        .chan_i(lo_chan), .time_i(time_us), .lvl_o(deb_lvl),
        .rise_o(deb_rise), .fall_o(deb_fall),
        .mark_t_o(mark_t), .mark_c_o(mark_c)
    );

    hopd_qualify #(.TW(TW), .LW(LW), .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN)) u_qual (
        .start_t(start_q), .end_t(mark_t), .ok_o(len_ok), .len_o(len_val)
    );

    hopd_errcnt #(.EW(EW)) u_err (
        .clk(clk), .rst_n(rst_n), .inc(drop), .cnt_o(drop_cnt)
    );

    assign hop  = (state_q == S_BURST) && !deb_fall && (lo_chan != chan_q);
    assign drop = ((state_q == S_BURST) && deb_fall && !len_ok) || hop;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (deb_rise) state_d = S_BURST;
            S_BURST: begin
                if (deb_fall)  state_d = S_IDLE;
                else if (hop)  state_d = S_DRAIN;
            end
            S_DRAIN: if (!deb_lvl) state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // outputs and burst capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pkt_valid <= 1'b0;
            pkt_chan  <= '0;
            pkt_start <= '0;
            pkt_len   <= '0;
            start_q   <= '0;
            chan_q    <= '0;
        end else begin
            pkt_valid <= 1'b0;
            if ((state_q == S_IDLE) && deb_rise) begin
                start_q <= mark_t;
                chan_q  <= mark_c;
            end
            if ((state_q == S_BURST) && deb_fall && len_ok) begin
                pkt_valid <= 1'b1;
                pkt_chan  <= chan_q;
                pkt_start <= start_q;
                pkt_len   <= len_val;
            end
        end
    end

    // R4
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |=> !pkt_valid);

    // R6
    len_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |-> (pkt_len >= LW'(MIN_LEN)) && (pkt_len <= LW'(MAX_LEN)));

    // R7
    drain_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_DRAIN) |-> !pkt_valid);

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        $past(!rst_n) |-> (!pkt_valid && drop_cnt == '0));
endmodule

// File: tb/test_hop_pkt_det.sv
module test_hop_pkt_det;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        samp_stb = 1'b0;
    logic        env_bit = 1'b0;
    logic [1:0]  lo_chan = 2'd0;
    logic [31:0] time_us = 32'd5000;
    logic        pkt_valid;
    logic [1:0]  pkt_chan;
    logic [31:0] pkt_start;
    logic [15:0] pkt_len;
    logic [7:0]  drop_cnt;

    hop_pkt_det i_hop_pkt_det (
        .clk(clk), .rst_n(rst_n), .samp_stb(samp_stb), .env_bit(env_bit),
        .lo_chan(lo_chan), .time_us(time_us), .pkt_valid(pkt_valid),
        .pkt_chan(pkt_chan), .pkt_start(pkt_start), .pkt_len(pkt_len),
        .drop_cnt(drop_cnt)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        logic [1:0]  ch;
        int unsigned st;
        int unsigned ln;
    } exp_t;

    exp_t q[$];
    int   n_chk = 0;
    int   n_fail = 0;
    int   exp_err = 0;
    int   sub = 0;
    bit   done = 0;
    bit   prev_v = 0;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // time base: one microsecond per ten clocks
    always @(negedge clk) begin
        if (!rst_n) begin
            sub = 0;
        end else if (sub == 9) begin
            sub = 0;
            time_us = time_us + 1;
        end else begin
            sub = sub + 1;
        end
    end

    // monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (pkt_valid) begin
                check(!prev_v, "R4 pulse width", 2, 1);
                if (q.size() == 0) begin
                    check(0, "R6/R7 unexpected descriptor", 1, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check(pkt_chan == e.ch, "R5 channel", pkt_chan, e.ch);
                    check(pkt_start == e.st, "R4 start", pkt_start, e.st);
                    check(pkt_len == e.ln[15:0], "R4 length", pkt_len, e.ln);
                end
            end
            prev_v = pkt_valid;
        end
    end

    task automatic idle_low(input int n);
        repeat (n) begin
            @(negedge clk); #1;
            env_bit = 1'b0;
            samp_stb = 1'b1;
        end
    endtask

    // drive a burst of exactly len microseconds
    task automatic drive_burst(input logic [1:0] ch, input int len, input bit gate,
                               input bit dropouts, input int hop_after,
                               input logic [1:0] hop_ch, input bit ok);
        int unsigned t0;
        int k;
        exp_t e;
        @(negedge clk); #1;
        lo_chan = ch;
        env_bit = 1'b1;
        samp_stb = 1'b1;
        t0 = time_us;
        k = 0;
        forever begin
            @(negedge clk); #1;
            k++;
            if (time_us == t0 + len) break;
            env_bit  = !(dropouts && ((k % 400) == 200 || (k % 400) == 201));
            samp_stb = gate ? k[0] : 1'b1;
            if (hop_after > 0 && (time_us - t0) >= hop_after) lo_chan = hop_ch;
        end
        env_bit = 1'b0;
        samp_stb = 1'b1;
        if (ok) begin
            e.ch = ch; e.st = t0; e.ln = len;
            q.push_back(e);
        end else begin
            exp_err++;
        end
        idle_low(30);
        lo_chan = ch;
    endtask

    task automatic check_state(input string req);
        check(q.size() == 0, {req, " descriptor count"}, q.size(), 0);
        check(drop_cnt == exp_err[7:0], {req, " drop count"}, drop_cnt, exp_err);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        // R1 reset state
        check(pkt_valid == 1'b0, "R1 valid", pkt_valid, 0);
        check(drop_cnt == 8'd0, "R1 drop count", drop_cnt, 0);
        rst_n = 1'b1;
        idle_low(20);

        // R4/R5 plain bursts on each channel
        drive_burst(2'd0, 200, 0, 0, 0, 2'd0, 1);
        check_state("R4");
        drive_burst(2'd1, 128, 0, 0, 0, 2'd1, 1);   // R6 lower edge
        check_state("R6 128");
        drive_burst(2'd2, 376, 0, 0, 0, 2'd2, 1);   // R6 upper edge
        check_state("R6 376");
        drive_burst(2'd0, 127, 0, 0, 0, 2'd0, 0);   // R6 too short
        check_state("R6 127");
        drive_burst(2'd1, 377, 0, 0, 0, 2'd1, 0);   // R6 too long
        check_state("R6 377");

        // R2 glitches of one and two high samples
        for (int g = 0; g < 6; g++) begin
            @(negedge clk); #1;
            env_bit = 1'b1; samp_stb = 1'b1;
            if (g[0]) begin
                @(negedge clk); #1;
                env_bit = 1'b1;
            end
            idle_low(5);
        end
        idle_low(20);
        check_state("R2 glitch");

        // R3 short dropouts inside a burst
        drive_burst(2'd2, 250, 0, 1, 0, 2'd2, 1);
        check_state("R3 dropout");

        // R7 channel hop during a burst
        drive_burst(2'd1, 200, 0, 0, 100, 2'd2, 0);
        check_state("R7 hop");

        // R8 high input with no strobe
        @(negedge clk); #1;
        samp_stb = 1'b0;
        env_bit = 1'b1;
        repeat (2000) begin
            @(negedge clk); #1;
            samp_stb = 1'b0;
            env_bit = 1'b1;
        end
        idle_low(30);
        check_state("R8 no strobe");

        // R8 half-rate strobe
        drive_burst(2'd1, 150, 1, 0, 0, 2'd1, 1);
        check_state("R8 gated");

        // recovery after hop and gating
        drive_burst(2'd0, 300, 0, 0, 0, 2'd0, 1);
        check_state("R5 recovery");

        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            check(0, "watchdog", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule